// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This unit carries out every stack operation for a small 8-bit processor core. It pushes and pulls the accumulator and the status byte, performs the subroutine call and return, and moves the stack pointer to or from the X index. It owns the 8-bit stack pointer, which wraps modulo 256 inside a fixed 256-byte page at `STACK_BASE`. It drives a synchronous single-port memory: address, write data and write enable are registered, and read data comes back one clock after the address is presented.

The core issues one command with `start` high for one cycle while `busy` is low. Each multi-byte command makes one memory access per clock. When the command completes, `done` pulses for one cycle, and the results appear on `res_byte`, `res_pc` and the N/Z flag outputs. While the unit is busy, `start` is not sampled.

Top module: `stack_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` stays high until the command completes, and `done` is high for exactly one cycle per accepted command. A `start` raised while `busy` is high has no effect on the stack pointer, the memory or the results. Command codes on `op`: 0 push A, 1 push status, 2 pull A, 3 pull status, 4 call, 5 return, 6 SP to X, 7 X to SP.
- R2: A push writes its byte to `STACK_BASE + SP` and then decrements SP modulo 256. Push A and push status leave `flag_we` low.
- R3: A pull increments SP modulo 256 and then reads `STACK_BASE + SP`. Pull A returns the byte on `res_byte` with `flag_we` high, `flag_n` equal to bit 7 of the byte, and `flag_z` set when the byte is zero.
- R4: Pull status returns the pulled byte ORed with 0x30 (bits 5 and 4 forced to 1) and leaves `flag_we` low.
- R5: Call first writes the high byte of `pc_in - 1` at `STACK_BASE + SP`, then writes the low byte at `STACK_BASE + SP - 1`. SP ends two lower, and `res_pc` equals `target_in`.
- R6: Return reads the low byte from `SP + 1` and then the high byte from `SP + 2`. SP ends two higher, and `res_pc` equals the pulled 16-bit value plus 1, modulo 65536.
- R7: SP to X puts SP on `res_byte` with `flag_we` high and N/Z taken from SP. X to SP loads SP from `x_in` with `flag_we` low.
- R8: After reset, SP is 0xFD and `done`, `busy`, `mem_we` and `flag_we` are low.
- R9: SP wraps across its ends. A push at SP 0x00 writes address 0x0100 and leaves SP at 0xFF. A pull at SP 0xFF reads address 0x0100 and leaves SP at 0x00.
- R10: `done` is high in cycle N after the accepting clock edge, where N is 1 for either transfer, 2 for a push, 3 for a pull or a call, and 4 for a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled while not busy |
| op | input | 3 | Command code |
| a_in | input | 8 | Accumulator value for push A |
| x_in | input | 8 | X value for X to SP |
| sr_in | input | 8 | Status value for push status |
| pc_in | input | 16 | PC already past the call instruction |
| target_in | input | 16 | Absolute call target |
| mem_addr | output | 16 | Memory address (registered) |
| mem_wdata | output | 8 | Memory write data (registered) |
| mem_we | output | 1 | Memory write enable (registered) |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_byte | output | 8 | Pulled byte or SP value |
| res_pc | output | 16 | New PC after call or return |
| flag_we | output | 1 | N/Z update strobe, valid with done |
| flag_n | output | 1 | Negative flag result |
| flag_z | output | 1 | Zero flag result |
| sp_q | output | 8 | Current stack pointer |

## Verification
The bench pushes 256 bytes, which walks SP once around the page and across the 0x00/0xFF boundary, and then pulls them all back. A design that decremented before writing, or incremented after reading, would return each byte from the wrong slot. The call and return checks use PC values whose low byte is 0x00, where the minus-one borrows into the high byte, and a PC of 0x0000, where the return's plus-one must wrap. A design that swapped byte order or skipped the adjustment would return to the wrong address. The bench also pulls status bytes with bits 5:4 clear, checks N/Z on zero and negative values, and raises `start` during a busy call to show that the request is dropped rather than applied to SP.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH_A  = 3'd0,
    OP_PUSH_SR = 3'd1,
    OP_PULL_A  = 3'd2,
    OP_PULL_SR = 3'd3,
    OP_CALL    = 3'd4,
    OP_RET     = 3'd5,
    OP_SP2X    = 3'd6,
    OP_X2SP    = 3'd7
  } stk_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CALL_LO,
    ST_FIN,
    ST_PL_WAIT,
    ST_PL_CAP,
    ST_RET_B,
    ST_RET_C,
    ST_RET_D
  } stk_state_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SP_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100,
  parameter logic [SP_W-1:0] SP_RESET = 8'hFD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sp_dec,
  input  logic              sp_inc,
  input  logic              sp_load,
  input  logic [SP_W-1:0]   load_val,
  output logic [SP_W-1:0]   sp,
  output logic [ADDR_W-1:0] addr_top,
  output logic [ADDR_W-1:0] addr_above
);
  localparam int PAD_W = ADDR_W - SP_W;

  logic [SP_W-1:0] sp_plus;

  always_ff @(posedge clk) begin
    if (rst)          sp <= SP_RESET;
    else if (sp_load) sp <= load_val;
    else if (sp_dec)  sp <= sp - 1'b1;
    else if (sp_inc)  sp <= sp + 1'b1;
  end

  // the page offset wraps inside SP_W bits, never into the base
  assign sp_plus    = sp + 1'b1;
  assign addr_top   = STACK_BASE + {{PAD_W{1'b0}}, sp};
  assign addr_above = STACK_BASE + {{PAD_W{1'b0}}, sp_plus};
endmodule

// File: rtl/stk_nz.sv
module stk_nz #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic         zero
);
  assign neg  = val[W-1];
  assign zero = (val == '0);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   sr_in,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [2*DATA_W-1:0] target_in,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic [SP_W-1:0]     sp,
  input  logic [ADDR_W-1:0]   addr_top,
  input  logic [ADDR_W-1:0]   addr_above,
  output logic                sp_dec,
  output logic                sp_inc,
  output logic                sp_load,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   res_byte,
  output logic [2*DATA_W-1:0] res_pc,
  output logic                flag_we,
  output logic                flag_n,
  output logic                flag_z
);
  localparam int PC_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] SR_FORCE = DATA_W'(8'h30);

  stk_state_e        state_q;
  stk_op_e           op_q;
  stk_op_e           op_in;
  logic              accept;
  logic [DATA_W-1:0] lo_q;
  logic [PC_W-1:0]   tgt_q;
  logic [PC_W-1:0]   ret_addr;
  logic [DATA_W-1:0] nz_src;
  logic              nz_n, nz_z;

  assign op_in    = stk_op_e'(op);
  assign accept   = (state_q == ST_IDLE) && start;
  assign busy     = (state_q != ST_IDLE);
  assign ret_addr = pc_in - 1'b1;

  // pointer moves: write-then-decrement, increment-then-read
  assign sp_dec  = (accept && (op_in == OP_PUSH_A || op_in == OP_PUSH_SR ||
                               op_in == OP_CALL)) || (state_q == ST_CALL_LO);
  assign sp_inc  = (accept && (op_in == OP_PULL_A || op_in == OP_PULL_SR ||
                               op_in == OP_RET)) || (state_q == ST_RET_B);
  assign sp_load = accept && (op_in == OP_X2SP);

  assign nz_src = (state_q == ST_PL_CAP) ? mem_rdata : DATA_W'(sp);

  stk_nz #(.W(DATA_W)) u_nz (.val(nz_src), .neg(nz_n), .zero(nz_z));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_PUSH_A;
      lo_q      <= '0;
      tgt_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      done      <= 1'b0;
      res_byte  <= '0;
      res_pc    <= '0;
      flag_we   <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      done    <= 1'b0;
      flag_we <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          op_q <= op_in;
          unique case (op_in)
            OP_PUSH_A, OP_PUSH_SR: begin
              mem_addr  <= addr_top;
              mem_wdata <= (op_in == OP_PUSH_A) ? a_in : sr_in;
              mem_we    <= 1'b1;
              state_q   <= ST_FIN;
            end
            OP_PULL_A, OP_PULL_SR: begin
              mem_addr <= addr_above;
              state_q  <= ST_PL_WAIT;
            end
            OP_CALL: begin
              mem_addr  <= addr_top;
              mem_wdata <= ret_addr[PC_W-1:DATA_W];
              mem_we    <= 1'b1;
              lo_q      <= ret_addr[DATA_W-1:0];
              tgt_q     <= target_in;
              state_q   <= ST_CALL_LO;
            end
            OP_RET: begin
              mem_addr <= addr_above;
              state_q  <= ST_RET_B;
            end
            OP_SP2X: begin
              res_byte <= DATA_W'(sp);
              flag_we  <= 1'b1;
              flag_n   <= nz_n;
              flag_z   <= nz_z;
              done     <= 1'b1;
            end
            default: done <= 1'b1;
          endcase
        end
        ST_CALL_LO: begin
          mem_addr  <= addr_top;
          mem_wdata <= lo_q;
          mem_we    <= 1'b1;
          state_q   <= ST_FIN;
        end
        ST_FIN: begin
          done    <= 1'b1;
          if (op_q == OP_CALL) res_pc <= tgt_q;
          state_q <= ST_IDLE;
        end
        ST_PL_WAIT: state_q <= ST_PL_CAP;
        ST_PL_CAP: begin
          done <= 1'b1;
          if (op_q == OP_PULL_A) begin
            res_byte <= mem_rdata;
            flag_we  <= 1'b1;
            flag_n   <= nz_n;
            flag_z   <= nz_z;
          end else begin
            res_byte <= mem_rdata | SR_FORCE;
          end
          state_q <= ST_IDLE;
        end
        ST_RET_B: begin
          mem_addr <= addr_above;
          state_q  <= ST_RET_C;
        end
        ST_RET_C: begin
          lo_q    <= mem_rdata;
          state_q <= ST_RET_D;
        end
        ST_RET_D: begin
          res_pc  <= {mem_rdata, lo_q} + 1'b1;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int DATA_W = 8,
  parameter int SP_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100,
  parameter logic [SP_W-1:0] SP_RESET = 8'hFD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   sr_in,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [2*DATA_W-1:0] target_in,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   res_byte,
  output logic [2*DATA_W-1:0] res_pc,
  output logic                flag_we,
  output logic                flag_n,
  output logic                flag_z,
  output logic [SP_W-1:0]     sp_q
);
  logic              sp_dec, sp_inc, sp_load;
  logic [ADDR_W-1:0] addr_top, addr_above;

  stk_ptr #(
    .SP_W(SP_W), .ADDR_W(ADDR_W), .STACK_BASE(STACK_BASE), .SP_RESET(SP_RESET)
  ) u_ptr (
    .clk(clk), .rst(rst), .sp_dec(sp_dec), .sp_inc(sp_inc), .sp_load(sp_load),
    .load_val(SP_W'(x_in)), .sp(sp_q), .addr_top(addr_top), .addr_above(addr_above)
  );

  stk_ctrl #(
    .DATA_W(DATA_W), .SP_W(SP_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(op), .a_in(a_in), .sr_in(sr_in),
    .pc_in(pc_in), .target_in(target_in), .mem_rdata(mem_rdata), .sp(sp_q),
    .addr_top(addr_top), .addr_above(addr_above), .sp_dec(sp_dec),
    .sp_inc(sp_inc), .sp_load(sp_load), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
    .res_byte(res_byte), .res_pc(res_pc), .flag_we(flag_we),
    .flag_n(flag_n), .flag_z(flag_z)
  );
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int DATA_W = 8,
  parameter int SP_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STACK_BASE = 16'h0100
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] x_in,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] res_byte,
  input logic              flag_we,
  input logic [SP_W-1:0]   sp_q
);
  localparam int PAD_W = ADDR_W - SP_W;

  logic [2:0]      last_op_q;
  logic [SP_W-1:0] sp_up;
  logic            acc;

  assign acc   = start && !busy;
  assign sp_up = sp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)      last_op_q <= 3'd0;
    else if (acc) last_op_q <= op;
  end

  // R2: every write lands one slot above the already-decremented pointer
  a_r2_write_above_sp: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == STACK_BASE + {{PAD_W{1'b0}}, sp_up});

  // R1: completion never overlaps a running command or a write
  a_r1_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_we));

  // R4: pulled status carries bits 5:4 set and no flag update
  a_r4_status_forced: assert property (@(posedge clk) disable iff (rst)
    (done && last_op_q == 3'd3) |-> (res_byte[5:4] == 2'b11 && !flag_we));

  // R7: X to SP loads the pointer in one cycle without touching flags
  a_r7_x_to_sp: assert property (@(posedge clk) disable iff (rst)
    (acc && op == 3'd7) |=> (done && !flag_we && sp_q == SP_W'($past(x_in))));

  // R7: SP to X returns the pointer with a flag update
  a_r7_sp_to_x: assert property (@(posedge clk) disable iff (rst)
    (acc && op == 3'd6) |=> (done && flag_we && res_byte == DATA_W'($past(sp_q))));
endmodule

bind stack_seq stack_seq_chk #(
  .DATA_W(DATA_W), .SP_W(SP_W), .ADDR_W(ADDR_W), .STACK_BASE(STACK_BASE)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .x_in(x_in),
  .mem_addr(mem_addr), .mem_we(mem_we), .busy(busy), .done(done),
  .res_byte(res_byte), .flag_we(flag_we), .sp_q(sp_q)
);

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [7:0]  a_in = 8'd0, x_in = 8'd0, sr_in = 8'd0;
  logic [15:0] pc_in = 16'd0, target_in = 16'd0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, res_byte, sp_q;
  logic        mem_we, busy, done, flag_we, flag_n, flag_z;
  logic [15:0] res_pc;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] m_sp;
  int tests = 0, fails = 0, last_lat = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .a_in(a_in), .x_in(x_in),
    .sr_in(sr_in), .pc_in(pc_in), .target_in(target_in), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .res_byte(res_byte), .res_pc(res_pc), .flag_we(flag_we),
    .flag_n(flag_n), .flag_z(flag_z), .sp_q(sp_q)
  );

  // synchronous memory, one-cycle read latency; writes outside the page are flagged
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_addr[15:8] == 8'h01) mem[mem_addr[7:0]] <= mem_wdata;
      else begin
        fails++; tests++;
        $display("FAIL R2 write outside page actual=%h expected=01xx", mem_addr);
      end
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [7:0] a, input logic [7:0] x,
                     input logic [7:0] s, input logic [15:0] p, input logic [15:0] t,
                     input int exp_lat);
    int lat;
    @(negedge clk);
    start = 1'b1; op = o; a_in = a; x_in = x; sr_in = s; pc_in = p; target_in = t;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    last_lat = lat;
    chk(lat == exp_lat, "R10 latency", lat, exp_lat);
  endtask

  task automatic push_a(input logic [7:0] v);
    logic [7:0] old = m_sp;
    run(3'd0, v, 8'd0, 8'd0, 16'd0, 16'd0, 2);
    shadow[old] = v;
    m_sp = old - 8'd1;
    chk(mem[old] == v, "R2 push data", mem[old], v);
    chk(sp_q == m_sp, (old == 8'h00) ? "R9 push wrap" : "R2 push sp", sp_q, m_sp);
    chk(!flag_we, "R2 push flags", flag_we, 0);
  endtask

  task automatic pull_a();
    logic [7:0] e;
    m_sp = m_sp + 8'd1;
    e = shadow[m_sp];
    run(3'd2, 8'd0, 8'd0, 8'd0, 16'd0, 16'd0, 3);
    chk(res_byte == e, "R3 pull data", res_byte, e);
    chk(sp_q == m_sp, (m_sp == 8'h00) ? "R9 pull wrap" : "R3 pull sp", sp_q, m_sp);
    chk(flag_we && flag_n == e[7] && flag_z == (e == 8'd0), "R3 pull N/Z",
        {flag_we, flag_n, flag_z}, {1'b1, e[7], e == 8'd0});
  endtask

  task automatic call_ret(input logic [15:0] p, input logic [15:0] t);
    logic [15:0] r = p - 16'd1;
    logic [7:0] s0 = m_sp;
    run(3'd4, 8'd0, 8'd0, 8'd0, p, t, 3);
    chk(mem[s0] == r[15:8], "R5 call high byte", mem[s0], r[15:8]);
    chk(mem[s0 - 8'd1] == r[7:0], "R5 call low byte", mem[s0 - 8'd1], r[7:0]);
    chk(sp_q == s0 - 8'd2, "R5 call sp", sp_q, s0 - 8'd2);
    chk(res_pc == t, "R5 call target", res_pc, t);
    run(3'd5, 8'd0, 8'd0, 8'd0, 16'd0, 16'd0, 4);
    chk(res_pc == p, "R6 return pc", res_pc, p);
    chk(sp_q == s0, "R6 return sp", sp_q, s0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'd0; shadow[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sp_q == 8'hFD, "R8 reset sp", sp_q, 8'hFD);
    chk(!done && !busy && !mem_we && !flag_we, "R8 reset outputs",
        {done, busy, mem_we, flag_we}, 0);
    m_sp = 8'hFD;

    // full lap around the page, through the 00/FF boundary
    for (int i = 0; i < 256; i++) push_a(8'(i) ^ 8'h5A);
    for (int i = 0; i < 256; i++) pull_a();

    // status round trip: bits 5:4 forced on pull
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v = 8'(i * 17) & 8'hCF;
      run(3'd1, 8'd0, 8'd0, v, 16'd0, 16'd0, 2);
      chk(mem[m_sp] == v && sp_q == m_sp - 8'd1, "R2 push status", mem[m_sp], v);
      run(3'd3, 8'd0, 8'd0, 8'd0, 16'd0, 16'd0, 3);
      chk(res_byte == (v | 8'h30), "R4 pull status", res_byte, v | 8'h30);
      chk(!flag_we && sp_q == m_sp, "R4 no flag update", {flag_we, sp_q}, {1'b0, m_sp});
    end

    // call/return with borrow and wrap of the adjustment
    call_ret(16'h1200, 16'hE000);
    call_ret(16'h0000, 16'h0300);
    call_ret(16'hABCD, 16'hFFFF);
    call_ret(16'h0101, 16'h0000);

    // transfers
    for (int i = 0; i < 4; i++) begin
      logic [7:0] xv = (i == 0) ? 8'h00 : (i == 1) ? 8'h80 : (i == 2) ? 8'h7F : 8'h01;
      run(3'd7, 8'd0, xv, 8'd0, 16'd0, 16'd0, 1);
      chk(sp_q == xv && !flag_we, "R7 x to sp", {flag_we, sp_q}, {1'b0, xv});
      m_sp = xv;
      run(3'd6, 8'd0, 8'd0, 8'd0, 16'd0, 16'd0, 1);
      chk(res_byte == xv && flag_we && flag_n == xv[7] && flag_z == (xv == 8'd0),
          "R7 sp to x", {flag_we, flag_n, flag_z, res_byte}, {1'b1, xv[7], xv == 8'd0, xv});
    end

    // call across the page boundary: SP 00 -> high at 0x0100, low at 0x01FF
    run(3'd7, 8'd0, 8'h00, 8'd0, 16'd0, 16'd0, 1);
    m_sp = 8'h00;
    call_ret(16'h4401, 16'h2222);
    chk(mem[8'hFF] == 8'h00 && mem[8'h00] == 8'h44, "R9 call wrap",
        {mem[8'h00], mem[8'hFF]}, 16'h4400);

    // start held during a busy call must be dropped
    run(3'd7, 8'd0, 8'h80, 8'd0, 16'd0, 16'd0, 1);
    @(negedge clk);
    start = 1'b1; op = 3'd4; pc_in = 16'h3000; target_in = 16'h5555;
    @(negedge clk);
    op = 3'd7; x_in = 8'h33;
    chk(busy, "R1 busy during call", busy, 1);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done, "R1 done after call", done, 1);
    chk(sp_q == 8'h7E, "R1 busy start ignored", sp_q, 8'h7E);
    chk(res_pc == 16'h5555, "R1 call result kept", res_pc, 16'h5555);
    @(negedge clk);
    chk(!done && sp_q == 8'h7E, "R1 done single pulse", {done, sp_q}, 9'h07E);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule